// File: doc/BRIEF.md
# Peripheral Access Filter for a Bus Bridge

This block sits on the request path of a bus bridge, between a set of bus masters and a bank of peripheral slots. For every incoming request it decides whether the transaction may continue to its target peripheral or must be aborted with an error response. The decision uses per-master flags, per-peripheral protection nibbles and a per-peripheral security level. Each master has a trusted-for-read flag, a trusted-for-write flag and a force-user flag. Each peripheral has trust, write, supervisor and buffer-writes bits. The 3-bit security level is expanded into an 8-bit read/write permission vector, with one read and one write bit for each pairing of secure or non-secure with privileged or user.

Control state is written through a single narrow register write port and resets to zero. After every reset the configuration must be loaded again. The decision is registered. The response appears one clock after the request and carries grant, error, and a bufferable hint for granted writes. Forwarding the data, converting to the peripheral bus protocol and buffering writes are done elsewhere.

Top module: `periph_access_filter`

## Requirements
- R1: After reset all master flags and peripheral nibbles are zero and rsp_valid, rsp_grant, rsp_error and rsp_bufferable are low. With every security level at 0, every request is then granted.
- R2: rsp_valid is high exactly in the cycle after a cycle with req_valid high. When rsp_valid is high, exactly one of rsp_grant and rsp_error is high. When rsp_valid is low, both are low.
- R3: When bit 0 (trust-protect) of the target nibble is set, a read is rejected unless the master's trusted-for-read flag is set, and a write is rejected unless its trusted-for-write flag is set.
- R4: When bit 1 (write-protect) of the target nibble is set, every write to that peripheral is rejected, whatever the master. Reads are not affected.
- R5: When bit 2 (supervisor-protect) of the target nibble is set, user-level requests are rejected and privileged requests pass this check.
- R6: A master whose force-user flag is set is treated as user-level in both the supervisor check and the security-level check, even when req_priv is high.
- R7: Security level L of the target selects a permission vector. The levels 0 to 7 map to FF, FE, FA, EA, AA, F0, E0 and C0 in hex. A request is rejected when bit {secure, effective_priv, !write} of that vector is 0. Bit 7 is secure-privileged read and bit 0 is non-secure-user write.
- R8: rsp_bufferable is high only with rsp_grant for a write, and only when bit 3 (buffer-writes) of the target nibble is set.
- R9: A write with cfg_target=0 loads master cfg_index with {force_user, trust_wr, trust_rd} from cfg_data[2:0]. A write with cfg_target=1 loads the nibble of peripheral cfg_index from cfg_data[3:0]. A master index at or above the master count is ignored. A request in the same cycle as a register write is decided with the old values.
- R10: With all peripheral nibbles zero, the trust, write and supervisor checks have no effect, whatever the master flags are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_target | input | 1 | 0 selects the master flags, 1 selects the peripheral nibble |
| cfg_index | input | 4 | Master or peripheral index |
| cfg_data | input | 4 | Write data |
| req_valid | input | 1 | Request present |
| req_master | input | 3 | Requesting master ID |
| req_periph | input | 4 | Target peripheral index |
| req_write | input | 1 | 1 for write, 0 for read |
| req_priv | input | 1 | Privileged request |
| req_secure | input | 1 | Secure request |
| sec_level | input | 48 | 3-bit security level per peripheral, peripheral p at [3p+2:3p] |
| rsp_valid | output | 1 | Decision present |
| rsp_grant | output | 1 | Transaction may proceed |
| rsp_error | output | 1 | Transaction aborted with error response |
| rsp_bufferable | output | 1 | Granted write may be buffered |

## Verification
Two cases are hard to reach from the ports. The first is a request that lands in the same clock as a register write that would change its outcome. The bench issues a write-protected write and the nibble update in one cycle, expects a grant, and then expects the following request to be rejected. The second is the interaction of force-user with the security-level table. For this the bench steps every level while driving all eight secure, privilege and direction combinations from both a normal master and a force-user master. It compares each result against its own copy of the level table.

// File: rtl/paf_pkg.sv
package paf_pkg;

    typedef struct packed {
        logic force_user;
        logic trust_wr;
        logic trust_rd;
    } mst_ctl_t;

    typedef struct packed {
        logic buf_wr;
        logic sup_prot;
        logic wr_prot;
        logic trust_prot;
    } prf_ctl_t;

    localparam int LVL_W  = 3;
    localparam int PERM_W = 8;

    // Permission vector bits: [7] sec-priv-R, [6] sec-priv-W, [5] sec-user-R,
    // [4] sec-user-W, [3] ns-priv-R, [2] ns-priv-W, [1] ns-user-R, [0] ns-user-W
    function automatic logic [PERM_W-1:0] level_to_perm(input logic [LVL_W-1:0] lvl);
        logic [PERM_W-1:0] v;
        case (lvl)
            3'd0:    v = 8'hFF;
            3'd1:    v = 8'hFE;
            3'd2:    v = 8'hFA;
            3'd3:    v = 8'hEA;
            3'd4:    v = 8'hAA;
            3'd5:    v = 8'hF0;
            3'd6:    v = 8'hE0;
            default: v = 8'hC0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/paf_cfg_regs.sv
module paf_cfg_regs
    import paf_pkg::*;
#(
    parameter int NUM_MST = 8,
    parameter int NUM_PRF = 16,
    parameter int IDX_W   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic                      cfg_target,
    input  logic [IDX_W-1:0]          cfg_index,
    input  logic [3:0]                cfg_data,
    output mst_ctl_t [NUM_MST-1:0]    mst_o,
    output prf_ctl_t [NUM_PRF-1:0]    prf_o
);
    typedef struct packed {
        mst_ctl_t [NUM_MST-1:0] mst;
        prf_ctl_t [NUM_PRF-1:0] prf;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    logic mst_hit, prf_hit;

    always_comb begin
        st_d    = st_q;
        mst_hit = ({1'b0, cfg_index} < (IDX_W+1)'(NUM_MST));
        prf_hit = ({1'b0, cfg_index} < (IDX_W+1)'(NUM_PRF));
        if (cfg_we) begin
            for (int i = 0; i < NUM_MST; i++) begin
                if (!cfg_target && mst_hit && (int'(cfg_index) == i)) begin
                    st_d.mst[i] = mst_ctl_t'(cfg_data[2:0]);
                end
            end
            for (int j = 0; j < NUM_PRF; j++) begin
                if (cfg_target && prf_hit && (int'(cfg_index) == j)) begin
                    st_d.prf[j] = prf_ctl_t'(cfg_data);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mst_o = st_q.mst;
    assign prf_o = st_q.prf;

endmodule

// File: rtl/paf_sec_xlate.sv
module paf_sec_xlate
    import paf_pkg::*;
#(
    parameter int NUM_PRF = 16
) (
    input  logic [NUM_PRF*LVL_W-1:0]       sec_level,
    output logic [NUM_PRF-1:0][PERM_W-1:0] perm_o
);
    for (genvar p = 0; p < NUM_PRF; p++) begin : g_xlate
        assign perm_o[p] = level_to_perm(sec_level[p*LVL_W +: LVL_W]);
    end
endmodule

// File: rtl/paf_decide.sv
module paf_decide
    import paf_pkg::*;
(
    input  mst_ctl_t          mst,
    input  prf_ctl_t          prf,
    input  logic [PERM_W-1:0] perm,
    input  logic              is_write,
    input  logic              is_priv,
    input  logic              is_secure,
    output logic              allow,
    output logic              bufferable
);
    logic eff_priv;
    logic trust_fail, wp_fail, sp_fail, lvl_fail;
    logic [2:0] perm_idx;

    always_comb begin
        eff_priv   = is_priv & ~mst.force_user;
        trust_fail = prf.trust_prot & (is_write ? ~mst.trust_wr : ~mst.trust_rd);
        wp_fail    = prf.wr_prot & is_write;
        sp_fail    = prf.sup_prot & ~eff_priv;
        perm_idx   = {is_secure, eff_priv, ~is_write};
        lvl_fail   = ~perm[perm_idx];
        allow      = ~(trust_fail | wp_fail | sp_fail | lvl_fail);
        bufferable = allow & is_write & prf.buf_wr;
    end
endmodule

// File: rtl/periph_access_filter.sv
module periph_access_filter
    import paf_pkg::*;
#(
    parameter int NUM_MST = 8,
    parameter int NUM_PRF = 16,
    localparam int MST_W  = $clog2(NUM_MST),
    localparam int PRF_W  = $clog2(NUM_PRF),
    localparam int IDX_W  = (MST_W > PRF_W) ? MST_W : PRF_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic                       cfg_target,
    input  logic [IDX_W-1:0]           cfg_index,
    input  logic [3:0]                 cfg_data,
    input  logic                       req_valid,
    input  logic [MST_W-1:0]           req_master,
    input  logic [PRF_W-1:0]           req_periph,
    input  logic                       req_write,
    input  logic                       req_priv,
    input  logic                       req_secure,
    input  logic [NUM_PRF*LVL_W-1:0]   sec_level,
    output logic                       rsp_valid,
    output logic                       rsp_grant,
    output logic                       rsp_error,
    output logic                       rsp_bufferable
);
    typedef struct packed {
        logic valid;
        logic grant;
        logic error;
        logic bufw;
    } rsp_state_t;

    mst_ctl_t [NUM_MST-1:0]         mst_cfg;
    prf_ctl_t [NUM_PRF-1:0]         prf_cfg;
    logic [NUM_PRF-1:0][PERM_W-1:0] perm_all;

    mst_ctl_t          mst_sel;
    prf_ctl_t          prf_sel;
    logic [PERM_W-1:0] perm_sel;
    logic              allow, bufferable;

    rsp_state_t st_d, st_q;

    paf_cfg_regs #(
        .NUM_MST(NUM_MST), .NUM_PRF(NUM_PRF), .IDX_W(IDX_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_target(cfg_target),
        .cfg_index(cfg_index), .cfg_data(cfg_data),
        .mst_o(mst_cfg), .prf_o(prf_cfg)
    );

    paf_sec_xlate #(.NUM_PRF(NUM_PRF)) u_xlate (
        .sec_level(sec_level), .perm_o(perm_all)
    );

    assign mst_sel  = mst_cfg[req_master];
    assign prf_sel  = prf_cfg[req_periph];
    assign perm_sel = perm_all[req_periph];

    paf_decide u_decide (
        .mst(mst_sel), .prf(prf_sel), .perm(perm_sel),
        .is_write(req_write), .is_priv(req_priv), .is_secure(req_secure),
        .allow(allow), .bufferable(bufferable)
    );

    always_comb begin
        st_d.valid = req_valid;
        st_d.grant = req_valid & allow;
        st_d.error = req_valid & ~allow;
        st_d.bufw  = req_valid & bufferable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid      = st_q.valid;
    assign rsp_grant      = st_q.grant;
    assign rsp_error      = st_q.error;
    assign rsp_bufferable = st_q.bufw;

endmodule

// File: rtl/paf_checker.sv
module paf_checker
    import paf_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_priv,
    input logic              req_secure,
    input mst_ctl_t          mst_sel,
    input prf_ctl_t          prf_sel,
    input logic [PERM_W-1:0] perm_sel,
    input logic              rsp_valid,
    input logic              rsp_grant,
    input logic              rsp_error,
    input logic              rsp_bufferable
);
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (rsp_valid == $past(req_valid)));

    assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_grant, rsp_error}) == 1);

    assert_quiet_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_grant && !rsp_error && !rsp_bufferable);

    assert_write_protect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(req_valid && req_write && prf_sel.wr_prot) |-> rsp_error);

    assert_user_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(req_valid && !req_priv && prf_sel.sup_prot) |-> rsp_error);

    assert_forced_user_R6: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(req_valid && mst_sel.force_user && prf_sel.sup_prot) |-> rsp_error);

    assert_level_deny_R7: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(req_valid && !perm_sel[{req_secure, req_priv & ~mst_sel.force_user, ~req_write}])
        |-> rsp_error);

    assert_bufferable_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_bufferable |-> rsp_grant);
endmodule

bind periph_access_filter paf_checker u_paf_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_priv(req_priv), .req_secure(req_secure), .mst_sel(mst_sel),
    .prf_sel(prf_sel), .perm_sel(perm_sel), .rsp_valid(rsp_valid),
    .rsp_grant(rsp_grant), .rsp_error(rsp_error), .rsp_bufferable(rsp_bufferable)
);

// File: tb/tb_periph_access_filter.sv
module tb_periph_access_filter;
    localparam int CLK_PERIOD = 10;
    localparam int NM = 8;
    localparam int NP = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0, cfg_target = 1'b0;
    logic [3:0] cfg_index = '0, cfg_data = '0;
    logic req_valid = 1'b0;
    logic [2:0] req_master = '0;
    logic [3:0] req_periph = '0;
    logic req_write = 1'b0, req_priv = 1'b0, req_secure = 1'b0;
    logic [NP*3-1:0] sec_level = '0;
    logic rsp_valid, rsp_grant, rsp_error, rsp_bufferable;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    logic [2:0] m_flags [NM];
    logic [3:0] p_nib [NP];

    always #(CLK_PERIOD/2) clk = ~clk;

    periph_access_filter #(.NUM_MST(NM), .NUM_PRF(NP)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_target(cfg_target),
        .cfg_index(cfg_index), .cfg_data(cfg_data), .req_valid(req_valid),
        .req_master(req_master), .req_periph(req_periph), .req_write(req_write),
        .req_priv(req_priv), .req_secure(req_secure), .sec_level(sec_level),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_error(rsp_error),
        .rsp_bufferable(rsp_bufferable)
    );

    function automatic logic [7:0] lvl_vec(input int l);
        logic [7:0] t [8] = '{8'hFF, 8'hFE, 8'hFA, 8'hEA, 8'hAA, 8'hF0, 8'hE0, 8'hC0};
        return t[l];
    endfunction

    function automatic bit model_grant(input int m, input int p, input bit w, input bit pr, input bit s);
        bit effp = pr & ~m_flags[m][2];
        logic [7:0] v = lvl_vec(int'(sec_level[p*3 +: 3]));
        if (p_nib[p][0] && (w ? !m_flags[m][1] : !m_flags[m][0])) return 1'b0;
        if (p_nib[p][1] && w) return 1'b0;
        if (p_nib[p][2] && !effp) return 1'b0;
        return v[{s, effp, ~w}];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input bit tgt, input int idx, input logic [3:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_target = tgt; cfg_index = 4'(idx); cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (tgt) p_nib[idx] = d;
        else if (idx < NM) m_flags[idx] = d[2:0];
    endtask

    // drive one request at a negedge, sample its response at the next negedge
    task automatic request(input int m, input int p, input bit w, input bit pr, input bit s,
                           input bit exp_g, input bit exp_b, input string req);
        req_valid = 1'b1; req_master = 3'(m); req_periph = 4'(p);
        req_write = w; req_priv = pr; req_secure = s;
        @(negedge clk);
        req_valid = 1'b0;
        check(req, {rsp_valid, rsp_grant, rsp_error}, {1'b1, exp_g, ~exp_g});
        check(req, 32'(rsp_bufferable), 32'(exp_b));
    endtask

    task automatic t_reset;
        check("R1 reset", {rsp_valid, rsp_grant, rsp_error, rsp_bufferable}, 4'b0);
        @(negedge clk);
        request(7, 15, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R1 open write");
        request(0, 0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R1 open read");
    endtask

    task automatic t_idle;
        @(negedge clk);
        check("R2 idle", {rsp_valid, rsp_grant, rsp_error}, 3'b0);
    endtask

    task automatic t_zero_nibbles;
        cfg_write(1'b0, 2, 4'b0100);
        request(2, 4, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R10 flags without nibble");
        request(2, 4, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R10 user read");
        cfg_write(1'b0, 2, 4'b0000);
    endtask

    task automatic t_trust;
        cfg_write(1'b1, 3, 4'b0001);
        cfg_write(1'b0, 1, 4'b0001);
        cfg_write(1'b0, 3, 4'b0010);
        request(1, 3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R3 trusted read");
        request(1, 3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R3 untrusted write");
        request(3, 3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R3 trusted write");
        request(3, 3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R3 untrusted read");
        request(2, 3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R3 no trust");
    endtask

    task automatic t_wp;
        cfg_write(1'b0, 6, 4'b0011);
        cfg_write(1'b1, 5, 4'b0010);
        request(6, 5, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R4 write blocked");
        request(0, 5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R4 write blocked m0");
        request(0, 5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R4 read passes");
    endtask

    task automatic t_sp_force;
        cfg_write(1'b1, 6, 4'b0100);
        request(0, 6, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R5 priv passes");
        request(0, 6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 user blocked");
        cfg_write(1'b0, 4, 4'b0100);
        request(4, 6, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R6 forced user blocked");
        request(5, 6, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R6 other master priv");
    endtask

    task automatic t_levels;
        for (int l = 0; l < 8; l++) begin
            sec_level[9*3 +: 3] = 3'(l);
            for (int c = 0; c < 8; c++) begin
                for (int mi = 0; mi < 2; mi++) begin
                    int m = (mi == 0) ? 0 : 4;
                    bit g = model_grant(m, 9, c[0], c[1], c[2]);
                    request(m, 9, c[0], c[1], c[2], g, 1'b0, $sformatf("R7 level %0d combo %0d m%0d", l, c, m));
                end
            end
        end
        sec_level[9*3 +: 3] = 3'd0;
    endtask

    task automatic t_bufw;
        cfg_write(1'b1, 10, 4'b1000);
        request(0, 10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R8 buffered write");
        request(0, 10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R8 read not buffered");
        request(0, 11, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R8 bit clear");
        cfg_write(1'b1, 10, 4'b1010);
        request(0, 10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R8 rejected write");
    endtask

    task automatic t_regport;
        // request and nibble write in the same cycle: old value decides
        @(negedge clk);
        cfg_we = 1'b1; cfg_target = 1'b1; cfg_index = 4'd12; cfg_data = 4'b0010;
        request(0, 12, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R9 same cycle old value");
        cfg_we = 1'b0; p_nib[12] = 4'b0010;
        request(0, 12, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R9 new value applied");
        // out-of-range master index is dropped (must not alias master 0)
        cfg_write(1'b0, 8, 4'b0100);
        request(0, 6, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R9 master index 8 ignored");
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < NM; i++) m_flags[i] = '0;
        for (int i = 0; i < NP; i++) p_nib[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_zero_nibbles();
        t_trust();
        t_wp();
        t_sp_force();
        t_levels();
        t_bufw();
        t_regport();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule